// File: doc/BRIEF.md
# Bridge Driver Fault and Standby Supervisor

This block decides when a two-phase motor bridge may drive its outputs and when the gate-drive charge pump may run. It watches two supply-good flags (logic rail and motor rail), an over-temperature flag, an overcurrent flag and an active-high run/standby pin. From these it derives a global output enable, a charge-pump enable and four status bits.

Either supply below its return threshold is an undervoltage condition. While it lasts, everything is held off and both fault latches are wiped. A thermal or overcurrent event is latched and shuts the bridge and pump down. The only way to release a latch is for the synchronised run pin to be seen low while the latch is set, followed by a rising edge. At that rising edge the fault flag must already be clear. When the block enters the running condition, the pump starts at once. The outputs stay inhibited for a programmable settling count while the pump voltage builds. The count starts again from the beginning after any interruption. All ports are plain level signals; no streaming interface is involved.

Top module: `drv_supervisor`

## Requirements
- R1: While `vdd_ok` or `vm_ok` is low, `out_en` and `pump_en` are 0 and `stat_uv` is 1 in the same cycle.
- R2: A clock edge at which undervoltage is present clears both `stat_ot` and `stat_oc`.
- R3: `run_req` passes through a two-flop synchroniser. It takes effect on `pump_en` after two clock edges, and while the synchronised level is low, `pump_en` and `out_en` are 0.
- R4: `ot_flag` high at a clock edge with supplies good sets `stat_ot` after that edge. While `stat_ot` is 1, `pump_en` and `out_en` are 0.
- R5: `oc_flag` high at a clock edge with supplies good sets `stat_oc` after that edge. While `stat_oc` is 1, `pump_en` and `out_en` are 0.
- R6: A set latch stays set until the synchronised `run_req` is seen low while the latch is set and then rises. A latch set while `run_req` stays high remains set.
- R7: If the fault flag is still high at the releasing rising edge, the latch stays set and a fresh low-then-high sequence is needed.
- R8: `pump_en` is 1 when the synchronised run level is high, supplies are good and no latch is set. `out_en` becomes 1 exactly `SETTLE_CYC` clock edges after `pump_en` rises. `stat_settle` is 1 during that interval.
- R9: Any drop of `pump_en` restarts the settling count from `SETTLE_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_ok | input | 1 | Logic supply above return threshold |
| vm_ok | input | 1 | Motor supply above return threshold |
| ot_flag | input | 1 | Over-temperature indication (synchronous) |
| oc_flag | input | 1 | Overcurrent indication (synchronous) |
| run_req | input | 1 | Run pin, high = operate, low = standby (asynchronous) |
| out_en | output | 1 | Global bridge output enable / motor ready |
| pump_en | output | 1 | Charge pump enable |
| stat_ot | output | 1 | Thermal fault latched |
| stat_oc | output | 1 | Overcurrent fault latched |
| stat_uv | output | 1 | Undervoltage present |
| stat_settle | output | 1 | Charge pump settling in progress |

## Verification
The assertions check, on every cycle, the conditions that can be stated per cycle:
- outputs forced off under undervoltage or while a latch is set;
- latches wiped by undervoltage, set by a flag, and kept while the flag persists or no rising edge occurs;
- no output enable in the cycle right after the pump was off.

The bench scenarios cover the rest:
- the exact settling length;
- clearing only after a low-then-high sequence on the run pin;
- refusal to clear while the temperature flag is still high;
- restart of the count after a brief standby pulse.

Randomised toggling of all inputs is compared cycle by cycle against a model built from the requirements.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
  localparam int FLT_THERM = 0;
  localparam int FLT_OVERI = 1;
  localparam int NUM_FLT   = 2;
endpackage

// File: rtl/run_sync.sv
module run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin};
  end

  assign lvl  = sh[1];
  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic uv,
  input  logic flag,
  input  logic run_lvl,
  input  logic run_rise,
  output logic lat
);
  logic armed;
  logic release_now;

  assign release_now = armed & run_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat   <= 1'b0;
      armed <= 1'b0;
    end else if (uv) begin
      lat   <= 1'b0;
      armed <= 1'b0;
    end else begin
      // a present flag wins over a release in the same cycle
      lat <= flag | (lat & ~release_now);
      if (run_rise)            armed <= 1'b0;
      else if (lat && !run_lvl) armed <= 1'b1;
    end
  end

  assert_uv_wipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> !lat);
  // R4 and R5: each instance guards one fault source
  assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !uv) |=> lat);
  assert_hold_no_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && !run_rise && !uv) |=> lat);
  assert_hold_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && flag && !uv) |=> lat);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= LOAD;
    else if (!run)      cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign ready = run && (cnt == '0);

  generate
    if (SETTLE_CYC > 0) begin : g_chk
      assert_settle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ready);
    end
  endgenerate
endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor
  import drv_sup_pkg::*;
#(
  parameter int SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_ok,
  input  logic vm_ok,
  input  logic ot_flag,
  input  logic oc_flag,
  input  logic run_req,
  output logic out_en,
  output logic pump_en,
  output logic stat_ot,
  output logic stat_oc,
  output logic stat_uv,
  output logic stat_settle
);
  logic uv;
  logic run_lvl, run_rise;
  logic [NUM_FLT-1:0] flags, lats;
  logic run, ready;

  assign uv = ~(vdd_ok & vm_ok);
  assign flags[FLT_THERM] = ot_flag;
  assign flags[FLT_OVERI] = oc_flag;

  run_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(run_req), .lvl(run_lvl), .rise(run_rise)
  );

  generate
    for (genvar k = 0; k < NUM_FLT; k++) begin : g_flt
      fault_latch u_lat (
        .clk(clk), .rst_n(rst_n), .uv(uv), .flag(flags[k]),
        .run_lvl(run_lvl), .run_rise(run_rise), .lat(lats[k])
      );
    end
  endgenerate

  assign run = run_lvl & ~uv & ~(|lats);

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .ready(ready)
  );

  assign pump_en     = run;
  assign out_en      = ready;
  assign stat_ot     = lats[FLT_THERM];
  assign stat_oc     = lats[FLT_OVERI];
  assign stat_uv     = uv;
  assign stat_settle = run & ~ready;

  assert_uv_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!vdd_ok || !vm_ok) |-> (!out_en && !pump_en));
  assert_standby_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lvl |-> (!pump_en && !out_en));
  assert_fault_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ot || stat_oc) |-> (!pump_en && !out_en));
  assert_en_needs_pump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> pump_en);
endmodule

// File: tb/sim_drv_supervisor.sv
module sim_drv_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int S = 12;

  logic clk = 0, rst_n = 0;
  logic vdd_ok = 1, vm_ok = 1, ot_flag = 0, oc_flag = 0, run_req = 0;
  logic out_en, pump_en, stat_ot, stat_oc, stat_uv, stat_settle;

  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_supervisor #(.SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vm_ok(vm_ok),
    .ot_flag(ot_flag), .oc_flag(oc_flag), .run_req(run_req),
    .out_en(out_en), .pump_en(pump_en), .stat_ot(stat_ot), .stat_oc(stat_oc),
    .stat_uv(stat_uv), .stat_settle(stat_settle)
  );

  // reference model from the requirements
  logic m_s1, m_s2, m_s3;
  logic m_lat [2];
  logic m_arm [2];
  int   m_cnt;

  function automatic logic f_uv(logic a, logic b);
    return !(a && b);
  endfunction

  function automatic logic f_run();
    return m_s2 && !f_uv(vdd_ok, vm_ok) && !m_lat[0] && !m_lat[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_cnt <= S;
      for (int k = 0; k < 2; k++) begin m_lat[k] <= 0; m_arm[k] <= 0; end
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (f_uv(vdd_ok, vm_ok)) begin
          m_lat[k] <= 0; m_arm[k] <= 0;
        end else begin
          m_lat[k] <= (k == 0 ? ot_flag : oc_flag) ||
                      (m_lat[k] && !(m_arm[k] && m_s2 && !m_s3));
          if (m_s2 && !m_s3)          m_arm[k] <= 0;
          else if (m_lat[k] && !m_s2) m_arm[k] <= 1;
        end
      end
      if (!f_run())        m_cnt <= S;
      else if (m_cnt != 0) m_cnt <= m_cnt - 1;
      m_s1 <= run_req; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic r;
    r = f_run();
    chk("R1 stat_uv", stat_uv, f_uv(vdd_ok, vm_ok));
    chk("R3 pump_en", pump_en, r);
    chk("R8 out_en", out_en, r && m_cnt == 0);
    chk("R8 stat_settle", stat_settle, r && m_cnt != 0);
    chk("R4 stat_ot", stat_ot, m_lat[0]);
    chk("R5 stat_oc", stat_oc, m_lat[1]);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seed;
    // reset state
    @(negedge clk); @(negedge clk);
    chk("R3 reset pump_en", pump_en, 0);
    chk("R8 reset out_en", out_en, 0);
    rst_n = 1;
    cyc(3);
    chk("R3 standby low", pump_en, 0);

    // power-up and settling length
    run_req = 1;
    cyc(1); chk("R3 one edge", pump_en, 0);
    cyc(1); chk("R3 two edges", pump_en, 1);
    cyc(S - 1); chk("R8 still settling", out_en, 0);
    chk("R8 settle flag", stat_settle, 1);
    cyc(1); chk("R8 ready", out_en, 1);

    // overcurrent pulse, no clear without low phase
    oc_flag = 1; cyc(1); oc_flag = 0;
    chk("R5 latched", stat_oc, 1);
    chk("R5 outputs off", out_en | pump_en, 0);
    cyc(6); chk("R6 held while run high", stat_oc, 1);
    run_req = 0; cyc(4); run_req = 1; cyc(4);
    chk("R6 cleared", stat_oc, 0);
    chk("R9 restart settle", out_en, 0);
    cyc(S + 2); chk("R8 ready again", out_en, 1);

    // thermal flag still high at release
    ot_flag = 1; cyc(2);
    chk("R4 latched", stat_ot, 1);
    run_req = 0; cyc(4); run_req = 1; cyc(4);
    chk("R7 hot no clear", stat_ot, 1);
    ot_flag = 0; cyc(3);
    chk("R7 needs new sequence", stat_ot, 1);
    run_req = 0; cyc(4); run_req = 1; cyc(4);
    chk("R7 cleared when cool", stat_ot, 0);

    // undervoltage wipes latches
    oc_flag = 1; cyc(1); oc_flag = 0;
    vm_ok = 0; cyc(1);
    chk("R2 wiped", stat_oc, 0);
    chk("R1 uv off", pump_en, 0);
    vm_ok = 1; cyc(S + 2);
    chk("R1 recover", out_en, 1);

    // brief standby pulse restarts count
    run_req = 0; cyc(4); run_req = 1; cyc(2 + S - 4);
    run_req = 0; cyc(1); run_req = 1; cyc(8);
    chk("R9 restarted", out_en, 0);
    cyc(S); chk("R9 ready later", out_en, 1);

    // constrained random
    seed = $urandom(32'd4242);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) run_req = ~run_req;
      ot_flag = ($urandom_range(0, 99) < 2);
      oc_flag = ($urandom_range(0, 99) < 2);
      vdd_ok  = ($urandom_range(0, 99) != 0);
      vm_ok   = ($urandom_range(0, 99) != 0);
      cyc(1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule